// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a serial chain of boundary cells that sits between the core logic and the chip pins. Each cell lies in one functional path. In normal operation the cell passes its parallel input straight to its parallel output. A test controller outside the block drives four controls, all qualified by the single block clock. The capture enable loads or shifts the first stage of every cell. The shift select decides whether that stage takes the parallel input or the neighbouring cell's bit. The update enable copies every first stage into a second holding stage in one cycle. The mode select makes the held values drive the outputs in place of the functional path.

Test data enters the chain one bit per shift cycle at the serial input and leaves at the serial output. Cell 0 is the cell nearest the serial output, and cell `CHAIN_LEN-1` is the cell nearest the serial input. A word shifted in least significant bit first therefore ends up with bit i in cell i. The same shifting that loads stimulus also unloads captured pin values, so one pass through the chain loads the next pattern and reads back the last one. The holding stage keeps the outputs still while the chain moves.

Top module: `bsr_chain`

## Requirements
- R1: While the test-logic reset `rst_n` is low, and after it is released, every capture stage and every update stage reads 0. With `mode` = 1 this makes `par_out` all zeros, and `scan_out` reads 0.
- R2: With `mode` = 0, `par_out[i]` equals `par_in[i]` combinationally, whatever the cell state.
- R3: With `mode` = 1, `par_out[i]` shows the update stage of cell i.
- R4: A clock edge with `dr_clk_en` = 1 and `dr_shift` = 0 loads `par_in[i]` into the capture stage of cell i.
- R5: A clock edge with `dr_clk_en` = 1 and `dr_shift` = 1 moves each capture bit from cell i+1 to cell i and loads `scan_in` into cell `CHAIN_LEN-1`. `scan_out` always shows the capture stage of cell 0.
- R6: A clock edge with `dr_clk_en` = 0 leaves every capture stage unchanged, even when `dr_shift` or `scan_in` toggles.
- R7: A clock edge with `dr_update` = 1 copies every capture stage into its update stage at once. If capture and update happen on the same edge, the update takes the capture value from before that edge.
- R8: Without `dr_update`, the update stages hold their value through shifting and capturing.
- R9: A bit presented at `scan_in` on a shift edge first appears at `scan_out` exactly `CHAIN_LEN` shift edges after it is taken in, counting its own edge.
- R10: Pulling `rst_n` low clears both stages at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all stage updates happen on its rising edge |
| rst_n | input | 1 | Test-logic reset, active low, asserted asynchronously |
| dr_clk_en | input | 1 | Capture-stage enable (capture or shift on this edge) |
| dr_shift | input | 1 | 1 selects the serial neighbour, 0 the parallel input |
| dr_update | input | 1 | Copies capture stages into update stages |
| mode | input | 1 | 1 drives outputs from update stages, 0 passes inputs through |
| scan_in | input | 1 | Serial test data into cell CHAIN_LEN-1 |
| par_in | input | CHAIN_LEN | Parallel data from pins or core, bit i to cell i |
| par_out | output | CHAIN_LEN | Parallel data to core or pins, bit i from cell i |
| scan_out | output | 1 | Serial test data out of cell 0 |

## Verification
A wrong capture bit stays hidden until it is shifted out. It shows at `scan_out` after as many shift edges as its distance from cell 0, so every check shifts the whole chain and compares bit by bit. A wrong update bit shows at `par_out` on the first cycle with `mode` high after the faulty edge, so the outputs are watched through every shift, hold and capture cycle. The moment a shift or hold disturbs the applied pattern is caught on that same cycle. The same-edge capture-and-update case and the one-hot latency pattern show an off-by-one in either stage or in the chain order.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  // Per-cell control bundle fanned out from the chain top
  typedef struct packed {
    logic cap_en;
    logic shift_sel;
    logic upd_en;
    logic drive_hold;
  } bsr_ctrl_t;

endpackage

// File: rtl/bsr_reset_sync.sv
module bsr_reset_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
  import bsr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bsr_ctrl_t ctrl,
  input  logic      ser_in,
  input  logic      func_in,
  output logic      cap_bit,
  output logic      hold_bit,
  output logic      func_out
);

  logic cap_q, cap_d;
  logic hold_q, hold_d;

  // Capture/shift stage next state
  always_comb begin
    cap_d = cap_q;
    if (ctrl.cap_en) begin
      cap_d = ctrl.shift_sel ? ser_in : func_in;
    end
  end

  // Update stage next state
  always_comb begin
    hold_d = hold_q;
    if (ctrl.upd_en) begin
      hold_d = cap_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      hold_q <= hold_d;
    end
  end

  assign func_out = ctrl.drive_hold ? hold_q : func_in;
  assign cap_bit  = cap_q;
  assign hold_bit = hold_q;

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int CHAIN_LEN   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dr_clk_en,
  input  logic                 dr_shift,
  input  logic                 dr_update,
  input  logic                 mode,
  input  logic                 scan_in,
  input  logic [CHAIN_LEN-1:0] par_in,
  output logic [CHAIN_LEN-1:0] par_out,
  output logic                 scan_out
);

  localparam int LAST = CHAIN_LEN - 1;

  logic                 rst_sync_n;
  bsr_ctrl_t            ctrl;
  logic [CHAIN_LEN-1:0] cap_vec;
  logic [CHAIN_LEN-1:0] hold_vec;
  logic [CHAIN_LEN:0]   ser_link;

  bsr_reset_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  always_comb begin
    ctrl.cap_en     = dr_clk_en;
    ctrl.shift_sel  = dr_shift;
    ctrl.upd_en     = dr_update;
    ctrl.drive_hold = mode;
  end

  // Serial path: scan_in feeds the top cell; each cell feeds the one below.
  assign ser_link[CHAIN_LEN] = scan_in;

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    bsr_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .ctrl     (ctrl),
      .ser_in   (ser_link[i+1]),
      .func_in  (par_in[i]),
      .cap_bit  (cap_vec[i]),
      .hold_bit (hold_vec[i]),
      .func_out (par_out[i])
    );
    assign ser_link[i] = cap_vec[i];
  end

  assign scan_out = ser_link[0];

  // Guard against chain lengths the serial indexing does not cover
  if (LAST < 1) begin : g_len_check
    $error("bsr_chain: CHAIN_LEN must be at least 2");
  end

endmodule

// File: rtl/bsr_chain_checker.sv
module bsr_chain_checker #(
  parameter int CHAIN_LEN = 8
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 dr_clk_en,
  input logic                 dr_shift,
  input logic                 dr_update,
  input logic                 mode,
  input logic                 scan_in,
  input logic [CHAIN_LEN-1:0] par_in,
  input logic [CHAIN_LEN-1:0] par_out,
  input logic [CHAIN_LEN-1:0] cap_vec,
  input logic [CHAIN_LEN-1:0] hold_vec
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (cap_vec == '0 && hold_vec == '0)); // R1

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mode |-> par_out == par_in); // R2

  AST_HOLD_DRIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode |-> par_out == hold_vec); // R3

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dr_clk_en && !dr_shift) |=> cap_vec == $past(par_in)); // R4

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dr_clk_en && dr_shift) |=>
      (cap_vec == {$past(scan_in), $past(cap_vec[CHAIN_LEN-1:1])})); // R5

  AST_CAP_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dr_clk_en |=> $stable(cap_vec)); // R6

  AST_UPDATE_COPY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dr_update |=> hold_vec == $past(cap_vec)); // R7

  AST_UPDATE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dr_update |=> $stable(hold_vec)); // R8

endmodule

bind bsr_chain bsr_chain_checker #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .dr_clk_en  (dr_clk_en),
  .dr_shift   (dr_shift),
  .dr_update  (dr_update),
  .mode       (mode),
  .scan_in    (scan_in),
  .par_in     (par_in),
  .par_out    (par_out),
  .cap_vec    (cap_vec),
  .hold_vec   (hold_vec)
);

// File: tb/bsr_chain_test.sv
`timescale 1ns/100ps
module bsr_chain_test;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         dr_clk_en, dr_shift, dr_update, mode, scan_in;
  logic [N-1:0] par_in;
  logic [N-1:0] par_out;
  logic         scan_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bsr_chain #(.CHAIN_LEN(N)) uut (
    .clk(clk), .rst_n(rst_n), .dr_clk_en(dr_clk_en), .dr_shift(dr_shift),
    .dr_update(dr_update), .mode(mode), .scan_in(scan_in), .par_in(par_in),
    .par_out(par_out), .scan_out(scan_out)
  );

  typedef struct {
    string        req;
    bit           is_serial;
    logic [N-1:0] exp;
  } exp_item_t;

  exp_item_t sb_q[$];
  event      sb_ev;

  // Requirement-level model of the two stages
  logic [N-1:0] m_cap, m_hold;

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expectations and compares once the design has settled
  initial begin
    forever begin
      @(sb_ev);
      #1;
      while (sb_q.size() > 0) begin
        exp_item_t it;
        it = sb_q.pop_front();
        if (it.is_serial) check(it.req, {{(N-1){1'b0}}, scan_out}, it.exp);
        else              check(it.req, par_out, it.exp);
      end
    end
  end

  task automatic push_par(string req, logic [N-1:0] v);
    sb_q.push_back('{req, 1'b0, v});
  endtask

  task automatic push_so(string req, logic v);
    sb_q.push_back('{req, 1'b1, {{(N-1){1'b0}}, v}});
  endtask

  task automatic flush();
    -> sb_ev;
    #2;
  endtask

  // One clock with the given controls; the model follows the requirements
  task automatic step(logic ce, logic sh, logic up, logic si);
    logic [N-1:0] nc, nh;
    dr_clk_en = ce; dr_shift = sh; dr_update = up; scan_in = si;
    nc = m_cap; nh = m_hold;
    if (up) nh = m_cap;
    if (ce) nc = sh ? {si, m_cap[N-1:1]} : par_in;
    @(posedge clk); #1;
    m_cap = nc; m_hold = nh;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] word;
    rst_n = 1'b0; dr_clk_en = 0; dr_shift = 0; dr_update = 0;
    mode = 1'b1; scan_in = 0; par_in = 8'hFF;
    m_cap = '0; m_hold = '0;
    repeat (3) @(posedge clk);
    #1;
    push_par("R1 outputs in reset", '0); push_so("R1 serial in reset", 1'b0); flush();
    rst_n = 1'b1;
    repeat (4) step(0, 0, 0, 0);
    push_par("R1 outputs after release", '0); push_so("R1 serial after release", 1'b0); flush();

    // Pass-through
    mode = 1'b0; par_in = 8'hA5; #1;
    push_par("R2 pass A5", 8'hA5); flush();
    par_in = 8'h3C; #1;
    push_par("R2 pass 3C", 8'h3C); flush();

    // Shift a word in LSB first while outputs hold
    mode = 1'b1; word = 8'h96;
    for (int k = 0; k < N; k++) begin
      step(1, 1, 0, word[k]);
      push_so("R5 shift-in serial", m_cap[0]);
      push_par("R8 hold during shift", m_hold); flush();
    end
    step(0, 0, 1, 0);
    push_par("R7 update applies 96", 8'h96);
    push_par("R3 drive from update", m_hold); flush();

    // Capture enable low: chain frozen
    for (int k = 0; k < 3; k++) begin
      step(0, 1, 0, k[0]);
      push_so("R6 serial frozen", m_cap[0]);
      push_par("R8 outputs frozen", 8'h96); flush();
    end

    // Parallel capture, then unload
    par_in = 8'h5B;
    step(1, 0, 0, 0);
    push_so("R4 captured bit0", 1'b1);
    push_par("R8 hold through capture", 8'h96); flush();
    word = '0;
    for (int k = 0; k < N; k++) begin
      word[k] = scan_out;
      step(1, 1, 0, 1'b1);
      push_so("R5 unload serial", m_cap[0]); flush();
    end
    check("R4 unloaded word", word, 8'h5B);

    // Latency: flush zeros then a single one
    for (int k = 0; k < N; k++) step(1, 1, 0, 0);
    step(1, 1, 0, 1);
    for (int k = 1; k < N; k++) begin
      push_so("R9 not yet out", 1'b0); flush();
      step(1, 1, 0, 0);
    end
    push_so("R9 out after N shifts", 1'b1); flush();

    // Capture and update on one edge: update sees old capture
    par_in = 8'hC3;
    step(1, 0, 1, 0);
    push_par("R7 same-edge update old value", m_hold); flush();
    check("R7 same-edge expected word", m_hold, 8'h01);
    step(0, 0, 1, 0);
    push_par("R7 later update new value", 8'hC3); flush();

    mode = 1'b0; par_in = 8'h18; #1;
    push_par("R2 pass with held data", 8'h18); flush();

    // Asynchronous clear between edges
    mode = 1'b1;
    rst_n = 1'b0; #0.5;
    check("R10 async clear outputs", par_out, '0);
    check("R10 async clear serial", {{(N-1){1'b0}}, scan_out}, '0);
    rst_n = 1'b1;

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule